// File: doc/BRIEF.md
# Serial Synthesizer Control Word Receiver

This block takes a 16-bit control word from a three-wire serial port. The port has an active-low enable, a serial clock and a data line. The block turns the word into two registered controls for a radio transceiver: a 15-bit channel divide number and a flag that selects low or full transmit power. All three serial lines are slow compared with the system clock. They are brought into the system clock domain through two-flop synchronizers, and their edges are detected there.

A word counts only if exactly sixteen clock rises arrive while enable is low. The channel part of such a word becomes active when enable is released, and a one-cycle strobe marks a change in its value. The power bit is held pending. It is applied only at the start of the next transmit burst, which is the falling edge of the receive/transmit line. A power change therefore never lands in the middle of a burst. A frame with the wrong bit count is discarded and sets a sticky error flag.

Top module: `synth_prog_if`

## Requirements
- R1: While rst_ni is low, and after it is released with no traffic, chan_o is 0, low_pwr_o is 0 (full power), chan_upd_o is 0 and frame_err_o is 0.
- R2: A word is sixteen bits sent first to last. The first bit is the power bit (1 = low power, 0 = full power). The next fifteen bits are channel bits, most significant first. After a valid frame, chan_o holds those fifteen bits with the first channel bit at chan_o[14].
- R3: A bit is taken on a rising edge of sclk_i only while sen_ni is low. sclk_i edges and sdata_i changes while sen_ni is high have no effect on any output or on the next frame.
- R4: chan_o keeps its old value for as long as sen_ni stays low, even after sixteen bits have been shifted. It takes the new value within 8 clk_i cycles after sen_ni rises.
- R5: chan_upd_o is high for exactly one cycle, in the cycle chan_o takes a value that differs from its previous one. A valid frame that repeats the current channel gives no strobe.
- R6: Releasing sen_ni after a valid frame does not change low_pwr_o. The frame's power bit is applied within 8 clk_i cycles after the next high-to-low transition of rxtx_i (1 = receive, 0 = transmit).
- R7: A frame loaded while rxtx_i is low leaves low_pwr_o unchanged for the rest of that burst. A rising edge of rxtx_i does not apply it either; only the following falling edge does.
- R8: When sen_ni rises after any number of bits other than sixteen, chan_o and the pending power bit keep their values, no strobe is given, and frame_err_o goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, idles high, data taken on rising edge |
| sen_ni | input | 1 | Serial enable, active low; rising edge ends a frame |
| sdata_i | input | 1 | Serial data |
| rxtx_i | input | 1 | 1 = receive, 0 = transmit; falling edge starts a burst |
| chan_o | output | 15 | Active channel divide number |
| chan_upd_o | output | 1 | One-cycle strobe when chan_o changes |
| low_pwr_o | output | 1 | Active power select, 1 = low power |
| frame_err_o | output | 1 | Sticky flag for a frame with the wrong bit count |

## Verification
The hardest situation to reach is a power setting that has been loaded but is still pending. It has to be observed across burst boundaries, and in particular when it is loaded while a burst is already running. The stimulus holds rxtx_i low, sends a frame with the opposite power bit, and confirms that low_pwr_o holds through the rest of the burst and through the return to receive. The new setting must appear only on the following falling edge. Bad-length frames are sent after a valid frame has left a pending power bit, so a later burst shows whether a discarded frame disturbed it.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CHAN_W = WORD_W - 1;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 2);
  typedef logic [CHAN_W-1:0] chan_t;
endpackage

// File: rtl/synth_prog_sync.sv
module synth_prog_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= RST_VAL;
    else         stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/synth_prog_shift.sv
module synth_prog_shift
  import synth_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              sen_s_i,
  input  logic              sdat_s_i,
  output logic [WORD_W-1:0] word_o,
  output logic              frame_ok_o,
  output logic              frame_bad_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic             sclk_q, sen_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sclk_rise, sen_fall, sen_rise;

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign sen_fall  = ~sen_s_i & sen_q;
  assign sen_rise  = sen_s_i & ~sen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      sen_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      sen_q  <= sen_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      word_o <= '0;
    end else if (sen_fall) begin
      cnt_q <= '0;
    end else if (sclk_rise && !sen_s_i) begin
      word_o <= {word_o[WORD_W-2:0], sdat_s_i};
      // saturate past full length so long frames stay flagged
      cnt_q  <= (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
    end
  end

  assign frame_ok_o  = sen_rise && (cnt_q == CNT_FULL);
  assign frame_bad_o = sen_rise && (cnt_q != CNT_FULL);
endmodule

// File: rtl/synth_prog_regs.sv
module synth_prog_regs
  import synth_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ok_i,
  input  logic              frame_bad_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              rxtx_s_i,
  output chan_t             chan_o,
  output logic              chan_upd_o,
  output logic              low_pwr_o,
  output logic              frame_err_o,
  output logic              burst_start_o
);
  logic  rxtx_q, pend_q;
  chan_t new_chan;
  logic  new_pwr;

  assign new_chan      = word_i[CHAN_W-1:0];
  assign new_pwr       = word_i[WORD_W-1];
  assign burst_start_o = rxtx_q & ~rxtx_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxtx_q      <= 1'b1;
      chan_o      <= '0;
      chan_upd_o  <= 1'b0;
      pend_q      <= 1'b0;
      low_pwr_o   <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      rxtx_q     <= rxtx_s_i;
      chan_upd_o <= frame_ok_i && (new_chan != chan_o);
      if (frame_ok_i) begin
        chan_o <= new_chan;
        pend_q <= new_pwr;
      end
      // a word landing on the burst edge wins over the older pending bit
      if (burst_start_o) low_pwr_o <= frame_ok_i ? new_pwr : pend_q;
      if (frame_bad_i)   frame_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sen_ni,
  input  logic              sdata_i,
  input  logic              rxtx_i,
  output logic [CHAN_W-1:0] chan_o,
  output logic              chan_upd_o,
  output logic              low_pwr_o,
  output logic              frame_err_o
);
  logic [3:0]        raw, syn;
  logic [WORD_W-1:0] word;
  logic              frame_ok, frame_bad, burst_start;

  assign raw = {sclk_i, sen_ni, sdata_i, rxtx_i};

  synth_prog_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1101)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  synth_prog_shift u_shift (
    .clk_i, .rst_ni,
    .sclk_s_i(syn[3]), .sen_s_i(syn[2]), .sdat_s_i(syn[1]),
    .word_o(word), .frame_ok_o(frame_ok), .frame_bad_o(frame_bad)
  );

  synth_prog_regs u_regs (
    .clk_i, .rst_ni,
    .frame_ok_i(frame_ok), .frame_bad_i(frame_bad), .word_i(word),
    .rxtx_s_i(syn[0]),
    .chan_o, .chan_upd_o, .low_pwr_o, .frame_err_o,
    .burst_start_o(burst_start)
  );
endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk
  import synth_prog_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CHAN_W-1:0] chan_o,
  input logic              chan_upd_o,
  input logic              low_pwr_o,
  input logic              frame_err_o,
  input logic              frame_ok,
  input logic              burst_start
);
  AST_UPD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_upd_o |=> !chan_upd_o); // R5
  AST_CHAN_CHANGE_STROBED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_o) |-> chan_upd_o); // R5
  AST_CHAN_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_o) |-> $past(frame_ok)); // R4
  AST_BAD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ok |=> $stable(chan_o)); // R8
  AST_PWR_AT_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(low_pwr_o) |-> $past(burst_start)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> frame_err_o); // R8
endmodule

bind synth_prog_if synth_prog_chk u_chk (
  .clk_i, .rst_ni, .chan_o, .chan_upd_o, .low_pwr_o, .frame_err_o,
  .frame_ok(frame_ok), .burst_start(burst_start)
);

// File: tb/synth_prog_if_test.sv
module synth_prog_if_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b1, sen_n = 1'b1, sdat = 1'b0, rxtx = 1'b1;
  logic [14:0] chan;
  logic upd, lowp, err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [14:0] exp_q[$];
  logic [14:0] exp_chan = '0;
  logic exp_pend = 1'b0, exp_act = 1'b0;

  always #4 clk = ~clk;

  synth_prog_if uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sen_ni(sen_n), .sdata_i(sdat),
    .rxtx_i(rxtx), .chan_o(chan), .chan_upd_o(upd), .low_pwr_o(lowp), .frame_err_o(err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(posedge clk);
  endtask

  // monitor: pops an expected channel on every strobe
  always @(negedge clk) begin
    if (rst_ni && upd) begin
      if (exp_q.size() == 0) check("R5 unexpected strobe", 32'(chan), 32'h7fffffff);
      else check("R5 strobe value", 32'(chan), 32'(exp_q.pop_front()));
    end
  end

  task automatic shift_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sclk <= 1'b0; sdat <= v[i]; clks(3);
      sclk <= 1'b1; clks(3);
    end
  endtask

  task automatic send(logic [31:0] v, int n);
    sen_n <= 1'b0; clks(3);
    shift_bits(v, n);
    sen_n <= 1'b1; clks(8);
  endtask

  task automatic load(logic pwr, logic [14:0] ch);
    if (ch != exp_chan) exp_q.push_back(ch);
    exp_chan = ch; exp_pend = pwr;
    send({16'h0, pwr, ch}, 16);
    @(negedge clk);
    check("R2 chan after frame", 32'(chan), 32'(exp_chan));
    check("R6 power not applied on release", 32'(lowp), 32'(exp_act));
  endtask

  task automatic burst();
    rxtx <= 1'b1; clks(8);
    rxtx <= 1'b0; clks(8);
    exp_act = exp_pend;
    @(negedge clk);
    check("R6 power at burst start", 32'(lowp), 32'(exp_act));
    rxtx <= 1'b1; clks(8);
  endtask

  initial begin
    clks(3);
    @(negedge clk);
    check("R1 chan reset", 32'(chan), 0);
    check("R1 lowp reset", 32'(lowp), 0);
    rst_ni <= 1'b1; clks(5);
    @(negedge clk);
    check("R1 upd idle", 32'(upd), 0);
    check("R1 err idle", 32'(err), 0);
    check("R1 chan idle", 32'(chan), 0);

    load(1'b0, 15'h1234);
    load(1'b1, 15'h4321);
    burst();
    load(1'b0, 15'h4321);   // same channel: R5 no strobe
    burst();

    // R3: stray clocks and data with enable high
    for (int k = 0; k < 5; k++) begin
      sdat <= 1'b1; sclk <= 1'b0; clks(3); sclk <= 1'b1; clks(3);
    end
    clks(6);
    @(negedge clk);
    check("R3 stray clocks chan", 32'(chan), 32'(exp_chan));
    check("R3 stray clocks err", 32'(err), 0);
    load(1'b0, 15'h0001);
    check("R3 frame after stray clocks", 32'(chan), 32'h0001);

    // R4: hold enable low after full word
    sen_n <= 1'b0; clks(3);
    shift_bits({16'h0, 1'b0, 15'h2aaa}, 16);
    clks(12);
    @(negedge clk);
    check("R4 chan held while enable low", 32'(chan), 32'(exp_chan));
    exp_q.push_back(15'h2aaa); exp_chan = 15'h2aaa; exp_pend = 1'b0;
    sen_n <= 1'b1; clks(8);
    @(negedge clk);
    check("R4 chan after release", 32'(chan), 32'h2aaa);

    // R7: load during a burst
    rxtx <= 1'b0; clks(8);
    exp_act = exp_pend;
    load(1'b1, 15'h7fff);
    clks(10);
    @(negedge clk);
    check("R7 lowp held during burst", 32'(lowp), 0);
    rxtx <= 1'b1; clks(8);
    @(negedge clk);
    check("R7 lowp held on return to receive", 32'(lowp), 0);
    rxtx <= 1'b0; clks(8);
    @(negedge clk);
    check("R7 lowp applied next burst", 32'(lowp), 1);
    exp_act = 1'b1;
    rxtx <= 1'b1; clks(8);

    // R8: pending power 0 loaded, then bad frames with power 1
    load(1'b0, 15'h0f0f);
    send({17'h0, 15'h7ff}, 15);
    @(negedge clk);
    check("R8 short frame chan", 32'(chan), 32'h0f0f);
    check("R8 short frame err", 32'(err), 1);
    send({15'h0, 2'b11, 15'h0}, 17);
    @(negedge clk);
    check("R8 long frame chan", 32'(chan), 32'h0f0f);
    burst();                                  // pending stays 0
    load(1'b0, 15'h0abc);
    check("R8 err sticky", 32'(err), 1);

    clks(5);
    check("R5 all strobes seen", 32'(exp_q.size()), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule